// File: doc/BRIEF.md
# Arbitrated Dual-Port RAM

This block is a clocked 2048-word by 8-bit memory with two fully independent sides, A (left) and B (right). Each side has its own active-low select, write strobe, address, write data and read data. Either side can read or write any word without regard to the other. Reads are registered, so data appears one clock after the read is issued.

When both sides are selected and present the same address, an arbiter decides which side arrived later and pulls that side's active-low busy line. Arrival is counted in clock cycles: a side arrives in the cycle in which its (select, address) pair takes a value it did not hold in the previous cycle. A busy side may still read, but its writes are discarded inside the block. The arbiter looks only at select and address, never at the write strobe.

A parameter builds the block either as an arbiter owner (master) or as a follower (slave). A follower never arbitrates. It drives its busy outputs inactive and takes two busy inputs, normally wired from a master's busy outputs, which block writes on the matching side. Several followers can then track one master's decision across a wider word.

Top module: `dpram_arbitrated`

## Requirements
- R1: Each side can write any of the 2048 words (addresses 0 to 2047). A read issued in one cycle returns that word's data on the side's read-data port after the next rising clock edge.
- R2: In master mode, when both sides are selected and their addresses differ, both busy outputs stay high (inactive).
- R3: When either select is high (inactive), both busy outputs stay high, even if the addresses match. A deselected side does not read or write, and its read-data port holds its last value.
- R4: In master mode, when both sides are selected at the same address, the side whose (select, address) pair changed in the current cycle gets busy low. A side whose pair held from the previous cycle proceeds.
- R5: When both sides arrive at the same matching address in the same cycle, the side named by the tie parameter gets busy low. By default this is side B.
- R6: Busy stays low on the same side for as long as both pairs are unchanged and still match.
- R7: The two busy outputs are never low in the same cycle.
- R8: Arbitration is the same whether each side reads or writes.
- R9: A write on a side whose busy is low is discarded in that same cycle. A read on that side still returns data.
- R10: When one side writes a word while the other side reads the same word in the same cycle, the reader gets the contents from before the write.
- R11: In slave mode, both busy outputs stay high and no arbitration takes place. A low level on a side's busy input discards that side's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_cs_n | input | 1 | Side A select, active low |
| a_wr | input | 1 | Side A write strobe (1 = write, 0 = read) |
| a_addr | input | 11 | Side A word address |
| a_wdata | input | 8 | Side A write data |
| a_rdata | output | 8 | Side A registered read data |
| b_cs_n | input | 1 | Side B select, active low |
| b_wr | input | 1 | Side B write strobe (1 = write, 0 = read) |
| b_addr | input | 11 | Side B word address |
| b_wdata | input | 8 | Side B write data |
| b_rdata | output | 8 | Side B registered read data |
| a_busy_in_n | input | 1 | Slave mode: side A write inhibit, active low; ignored in master mode |
| b_busy_in_n | input | 1 | Slave mode: side B write inhibit, active low; ignored in master mode |
| a_busy_n | output | 1 | Side A busy, active low (high in slave mode) |
| b_busy_n | output | 1 | Side B busy, active low (high in slave mode) |

## Verification
The hardest situation to reach is one where arrival history, rather than the current inputs, decides the outcome. Identical input values must flag side A in one cycle and side B in another, depending on which pair changed most recently. The stimulus table is therefore an ordered sequence, not a set of independent cases. It parks one side on an address and then moves the other side onto it, swaps the roles, and holds a collision for several cycles. It also brings both sides onto a fresh address in the same cycle. Discarded writes cannot be seen directly, so later reads expose them: a blocked value must never appear when the word is read back.

// File: rtl/dpra_pkg.sv
package dpra_pkg;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/dpra_arbiter.sv
module dpra_arbiter
  import dpra_pkg::*;
#(
  parameter int    AW        = 11,
  parameter side_e TIE_LOSER = SIDE_B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_cs_n,
  input  logic [AW-1:0] a_addr,
  input  logic          b_cs_n,
  input  logic [AW-1:0] b_addr,
  output logic          busy_a_n,
  output logic          busy_b_n
);

  logic          a_on, b_on;
  logic          a_prev_on, b_prev_on;
  logic [AW-1:0] a_prev_addr, b_prev_addr;
  logic          a_new, b_new;
  logic          match;
  side_e         held_loser, loser;
  logic          past_valid;

  assign a_on  = ~a_cs_n;
  assign b_on  = ~b_cs_n;
  assign match = a_on && b_on && (a_addr == b_addr);

  // A side arrives when its (select, address) pair differs from last cycle.
  assign a_new = a_on && (!a_prev_on || (a_prev_addr != a_addr));
  assign b_new = b_on && (!b_prev_on || (b_prev_addr != b_addr));

  always_comb begin
    loser = held_loser;
    if (a_new && b_new) loser = TIE_LOSER;
    else if (a_new)     loser = SIDE_A;
    else if (b_new)     loser = SIDE_B;
  end

  assign busy_a_n = !(match && (loser == SIDE_A));
  assign busy_b_n = !(match && (loser == SIDE_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev_on   <= 1'b0;
      b_prev_on   <= 1'b0;
      a_prev_addr <= '0;
      b_prev_addr <= '0;
      held_loser  <= SIDE_B;
      past_valid  <= 1'b0;
    end else begin
      a_prev_on   <= a_on;
      b_prev_on   <= b_on;
      a_prev_addr <= a_addr;
      b_prev_addr <= b_addr;
      past_valid  <= 1'b1;
      if (match) held_loser <= loser;
    end
  end

  // R7
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!busy_a_n && !busy_b_n));

  // R2
  busy_idle_nomatch_chk: assert property (@(posedge clk) disable iff (rst)
    (a_addr != b_addr) |-> (busy_a_n && busy_b_n));

  // R3
  busy_idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    (a_cs_n || b_cs_n) |-> (busy_a_n && busy_b_n));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (past_valid && match && $past(match) && $stable(a_addr) && $stable(b_addr))
      |-> ($stable(busy_a_n) && $stable(busy_b_n)));

endmodule

// File: rtl/dpra_storage.sv
module dpra_storage #(
  parameter int AW           = 11,
  parameter int DW           = 8,
  parameter bit EXCLUSIVE_WR = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_rd,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_rd,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  // Nonblocking reads see the contents from before this edge's writes.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= mem[a_addr];
      if (b_rd) b_rdata <= mem[b_addr];
    end
  end

  // R9
  no_dual_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(EXCLUSIVE_WR && a_we && b_we && (a_addr == b_addr)));

endmodule

// File: rtl/dpram_arbitrated.sv
module dpram_arbitrated
  import dpra_pkg::*;
#(
  parameter int AW             = 11,
  parameter int DW             = 8,
  parameter bit IS_MASTER      = 1'b1,
  parameter bit TIE_LOSER_SIDE_B = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  input  logic          a_busy_in_n,
  input  logic          b_busy_in_n,
  output logic          a_busy_n,
  output logic          b_busy_n
);

  localparam side_e TIE_SIDE = TIE_LOSER_SIDE_B ? SIDE_B : SIDE_A;

  logic a_inhibit, b_inhibit;
  logic a_rd_go, b_rd_go, a_we_go, b_we_go;

  generate
    if (IS_MASTER) begin : g_master
      logic arb_a_n, arb_b_n;
      logic unused_busy_in;

      dpra_arbiter #(
        .AW       (AW),
        .TIE_LOSER(TIE_SIDE)
      ) u_arbiter (
        .clk     (clk),
        .rst     (rst),
        .a_cs_n  (a_cs_n),
        .a_addr  (a_addr),
        .b_cs_n  (b_cs_n),
        .b_addr  (b_addr),
        .busy_a_n(arb_a_n),
        .busy_b_n(arb_b_n)
      );

      assign unused_busy_in = a_busy_in_n ^ b_busy_in_n;
      assign a_busy_n  = arb_a_n;
      assign b_busy_n  = arb_b_n;
      // Internal decision gates writes, not the external line level.
      assign a_inhibit = !arb_a_n;
      assign b_inhibit = !arb_b_n;
    end else begin : g_slave
      assign a_busy_n  = 1'b1;
      assign b_busy_n  = 1'b1;
      assign a_inhibit = !a_busy_in_n;
      assign b_inhibit = !b_busy_in_n;
    end
  endgenerate

  assign a_rd_go = !a_cs_n && !a_wr;
  assign b_rd_go = !b_cs_n && !b_wr;
  assign a_we_go = !a_cs_n && a_wr && !a_inhibit;
  assign b_we_go = !b_cs_n && b_wr && !b_inhibit;

  dpra_storage #(
    .AW          (AW),
    .DW          (DW),
    .EXCLUSIVE_WR(IS_MASTER)
  ) u_storage (
    .clk    (clk),
    .rst    (rst),
    .a_rd   (a_rd_go),
    .a_we   (a_we_go),
    .a_addr (a_addr),
    .a_wdata(a_wdata),
    .a_rdata(a_rdata),
    .b_rd   (b_rd_go),
    .b_we   (b_we_go),
    .b_addr (b_addr),
    .b_wdata(b_wdata),
    .b_rdata(b_rdata)
  );

  // R11
  slave_busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !IS_MASTER |-> (a_busy_n && b_busy_n));

endmodule

// File: tb/dpram_arbitrated_bench.sv
module dpram_arbitrated_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_cs_n = 1'b1, a_wr = 1'b0, b_cs_n = 1'b1, b_wr = 1'b0;
  logic [10:0] a_addr = '0, b_addr = '0;
  logic [7:0]  a_wdata = '0, b_wdata = '0;
  logic        s_a_busy_in_n = 1'b1, s_b_busy_in_n = 1'b1;
  logic [7:0]  a_rdata, b_rdata, s_a_rdata, s_b_rdata;
  logic        a_busy_n, b_busy_n, s_a_busy_n, s_b_busy_n;
  int          n_checks = 0;
  int          n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_arbitrated u_dpram_arbitrated (
    .clk(clk), .rst(rst),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .a_busy_in_n(1'b1), .b_busy_in_n(1'b1),
    .a_busy_n(a_busy_n), .b_busy_n(b_busy_n)
  );

  dpram_arbitrated #(.IS_MASTER(1'b0)) u_dpram_arbitrated_slave (
    .clk(clk), .rst(rst),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(s_a_rdata),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(s_b_rdata),
    .a_busy_in_n(s_a_busy_in_n), .b_busy_in_n(s_b_busy_in_n),
    .a_busy_n(s_a_busy_n), .b_busy_n(s_b_busy_n)
  );

  typedef struct packed {
    logic        acs;
    logic [10:0] aad;
    logic        awr;
    logic [7:0]  awd;
    logic        bcs;
    logic [10:0] bad;
    logic        bwr;
    logic [7:0]  bwd;
    logic        exp_a;
    logic        exp_b;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 11'd5, 1'b1, 8'h11, 1'b1, 11'd0, 1'b0, 8'h00, 1'b1, 1'b1}, // R3 B off
    '{1'b0, 11'd5, 1'b0, 8'h00, 1'b0, 11'd9, 1'b0, 8'h00, 1'b1, 1'b1}, // R2 differ
    '{1'b0, 11'd5, 1'b0, 8'h00, 1'b0, 11'd5, 1'b1, 8'h22, 1'b1, 1'b0}, // R4 B later
    '{1'b0, 11'd5, 1'b0, 8'h00, 1'b0, 11'd5, 1'b1, 8'h22, 1'b1, 1'b0}, // R6 held
    '{1'b0, 11'd6, 1'b0, 8'h00, 1'b0, 11'd5, 1'b1, 8'h33, 1'b1, 1'b1}, // R2 split
    '{1'b0, 11'd5, 1'b1, 8'h44, 1'b0, 11'd5, 1'b1, 8'h33, 1'b0, 1'b1}, // R4 A later
    '{1'b1, 11'd0, 1'b0, 8'h00, 1'b1, 11'd0, 1'b0, 8'h00, 1'b1, 1'b1}, // R3 both off
    '{1'b0, 11'd7, 1'b1, 8'h55, 1'b0, 11'd7, 1'b1, 8'h66, 1'b1, 1'b0}, // R5 tie
    '{1'b1, 11'd7, 1'b0, 8'h00, 1'b0, 11'd7, 1'b0, 8'h00, 1'b1, 1'b1}, // R3 A off
    '{1'b0, 11'd7, 1'b0, 8'h00, 1'b0, 11'd7, 1'b0, 8'h00, 1'b0, 1'b1}, // R8 reads
    '{1'b0, 11'd7, 1'b0, 8'h00, 1'b1, 11'd7, 1'b0, 8'h00, 1'b1, 1'b1}, // R3 B off
    '{1'b0, 11'd7, 1'b0, 8'h00, 1'b0, 11'd7, 1'b0, 8'h00, 1'b1, 1'b0}  // R8 B later
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic acs, input logic [10:0] aad, input logic awr,
                     input logic [7:0] awd, input logic bcs, input logic [10:0] bad,
                     input logic bwr, input logic [7:0] bwd);
    @(negedge clk);
    a_cs_n = acs; a_addr = aad; a_wr = awr; a_wdata = awd;
    b_cs_n = bcs; b_addr = bad; b_wr = bwr; b_wdata = bwd;
  endtask

  task automatic after_edge;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset R1 a_rdata", a_rdata, 8'h00);
    chk("reset R1 b_rdata", b_rdata, 8'h00);
    chk("reset R3 busy", {6'd0, a_busy_n, b_busy_n}, 8'h03);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      drv(VECS[i].acs, VECS[i].aad, VECS[i].awr, VECS[i].awd,
          VECS[i].bcs, VECS[i].bad, VECS[i].bwr, VECS[i].bwd);
      #(CLK_PERIOD/4);
      chk($sformatf("R4/R7 master busy vec %0d", i), {6'd0, a_busy_n, b_busy_n},
          {6'd0, VECS[i].exp_a, VECS[i].exp_b});
      chk($sformatf("R11 slave busy vec %0d", i), {6'd0, s_a_busy_n, s_b_busy_n}, 8'h03);
    end

    // R9: blocked writes 0x22 and 0x44 never reach word 5; R5 tie kept 0x55 in word 7
    drv(1'b0, 11'd5, 1'b0, 8'h00, 1'b0, 11'd7, 1'b0, 8'h00);
    after_edge();
    chk("R9 word 5", a_rdata, 8'h33);
    chk("R5 word 7", b_rdata, 8'h55);

    // R1: extreme addresses
    drv(1'b0, 11'd0, 1'b1, 8'hC3, 1'b0, 11'd2047, 1'b1, 8'h3C);
    drv(1'b0, 11'd2047, 1'b0, 8'h00, 1'b0, 11'd0, 1'b0, 8'h00);
    after_edge();
    chk("R1 addr 2047", a_rdata, 8'h3C);
    chk("R1 addr 0", b_rdata, 8'hC3);

    // R10 / R9: A holds word 20 and writes, B arrives reading the same word
    drv(1'b0, 11'd20, 1'b1, 8'h10, 1'b1, 11'd0, 1'b0, 8'h00);
    drv(1'b0, 11'd20, 1'b1, 8'h77, 1'b0, 11'd20, 1'b0, 8'h00);
    #(CLK_PERIOD/4);
    chk("R9 reader busy", {6'd0, a_busy_n, b_busy_n}, 8'h02);
    after_edge();
    chk("R10 old data", b_rdata, 8'h10);
    drv(1'b1, 11'd20, 1'b0, 8'h00, 1'b1, 11'd20, 1'b0, 8'h00);
    after_edge();
    chk("R3 rdata held", b_rdata, 8'h10);
    drv(1'b1, 11'd0, 1'b0, 8'h00, 1'b0, 11'd20, 1'b0, 8'h00);
    after_edge();
    chk("R10 new data", b_rdata, 8'h77);

    // R11: slave write inhibit from busy input
    drv(1'b0, 11'd100, 1'b1, 8'h5A, 1'b1, 11'd0, 1'b0, 8'h00);
    drv(1'b0, 11'd100, 1'b1, 8'hA5, 1'b1, 11'd0, 1'b0, 8'h00);
    s_a_busy_in_n = 1'b0;
    drv(1'b0, 11'd100, 1'b0, 8'h00, 1'b1, 11'd0, 1'b0, 8'h00);
    s_a_busy_in_n = 1'b1;
    after_edge();
    chk("R11 slave blocked", s_a_rdata, 8'h5A);
    chk("R11 master unaffected", a_rdata, 8'hA5);

    drv(1'b1, 11'd0, 1'b0, 8'h00, 1'b1, 11'd0, 1'b0, 8'h00);
    after_edge();
    summary();
  end
endmodule